// File: doc/BRIEF.md
# Trapdoor Configuration Register Gate

This block sits on the device side of a legacy IDE task-file port and decodes the host's byte and 16-bit cycles on port offsets 0 to 7. Normally every cycle is handed to the task-file interface untouched. A small bank of timing and control registers is hidden behind an unlock pattern built from ordinary cycles: two back-to-back 16-bit reads of the error offset, then a byte write of a key value to offset 2. While the gate is open, byte writes are taken by the register bank and are not passed on. A second key value written to offset 2 closes it again.

The bank holds a read-cycle timing byte and a write-cycle timing byte for each attached drive, one shared address-setup byte, a drive selector and a strap-override flag. While the override flag is clear, the timing outputs carry the slowest defaults instead of the programmed values. A separate probe lets software read the strapped bus-clock selection through the data port.

Top module: `trapdoor_gate`

## Requirements
- R1: After reset the gate is closed and the override flag is clear. The drive selector is 0, and every programmed timing byte holds its slowest default (data 0x6B, address setup 0x30).
- R2: While the gate is closed, every cycle is forwarded to the task-file outputs unchanged in the same cycle, and read data comes from the task file. The one exception is the clock-probe read of R11.
- R3: The gate opens on the clock edge that accepts a byte write of 0x03 to offset 2, when the two bus cycles just before it were 16-bit reads of offset 1. Cycles with bus_valid low do not count and do not break the pattern. A run of more than two such reads also qualifies.
- R4: Any other bus cycle inside the pattern returns the detector to idle, and the gate stays closed. This includes a cycle at another offset, a byte read of offset 1, or a different value written to offset 2.
- R5: While the gate is open, byte writes are not forwarded to the task file. 16-bit writes and all reads are still forwarded.
- R6: An open byte write to offset 6 with a value below the drive count (0 or 1) selects that drive. Any other value written there becomes the shared address-setup byte.
- R7: Open byte writes to offset 0 and offset 1 set the read-cycle and write-cycle timing bytes of the selected drive only. Drive d occupies bits [8d+7:8d] of each timing output.
- R8: An open byte write to offset 3 sets the override flag if the value is 0x85 and clears it for any other value.
- R9: While the override flag is set, the timing outputs show the programmed bytes. While it is clear, they show the defaults, and the programmed bytes are kept.
- R10: An open byte write of 0x83 to offset 2 closes the gate from the next cycle on. That write is not forwarded, and the register contents stay as they were.
- R11: After a byte write of 0xFF to offset 5, a 16-bit read of offset 5 as the very next bus cycle is not forwarded. It returns the strap clock select in bit 0 and zeros above it.
- R12: While the gate is closed, no bus cycle changes any timing output or the override flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | A host cycle is present this clock |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_wide | input | 1 | 1 for a 16-bit cycle, 0 for a byte cycle |
| bus_addr | input | 3 | Port offset 0 to 7 |
| bus_wdata | input | 16 | Write data (byte cycles use bits 7:0) |
| bus_rdata | output | 16 | Read data returned to the host |
| tf_valid | output | 1 | Cycle forwarded to the task file |
| tf_write | output | 1 | Forwarded direction |
| tf_wide | output | 1 | Forwarded width |
| tf_addr | output | 3 | Forwarded offset |
| tf_wdata | output | 16 | Forwarded write data |
| tf_rdata | input | 16 | Read data from the task file |
| strap_clk | input | 1 | Strapped bus-clock selection |
| rd_time_o | output | 16 | Effective read-cycle timing, one byte per drive |
| wr_time_o | output | 16 | Effective write-cycle timing, one byte per drive |
| addr_setup_o | output | 8 | Effective shared address-setup timing |
| timing_override_o | output | 1 | Programmed timing overrides the strap defaults |
| cfg_unlocked_o | output | 1 | Configuration gate is open |

## Verification
A detector stuck in the wrong state shows up at once. Either a register write leaks onto tf_valid in the same cycle, or cfg_unlocked_o disagrees with the model one edge after the key write. A bank entry written to the wrong drive or the wrong field stays hidden while the override flag is clear, so the stimulus sets the override repeatedly. Once it is set, the misplaced byte appears on the timing outputs one edge after the write. A probe flag that is armed when it should not be replaces the task-file read data in that same read cycle.

// File: rtl/trapdoor_pkg.sv
// Shared constants and types for the trapdoor configuration gate.
// Assumes a task-file port of eight offsets and 16-bit host data.
package trapdoor_pkg;
    localparam int TF_ADDR_W = 3;
    localparam int TF_DATA_W = 16;
    localparam int CFG_W     = 8;

    localparam logic [TF_ADDR_W-1:0] OFS_RDT   = 3'd0;
    localparam logic [TF_ADDR_W-1:0] OFS_WRT   = 3'd1;
    localparam logic [TF_ADDR_W-1:0] OFS_ERR   = 3'd1;
    localparam logic [TF_ADDR_W-1:0] OFS_KEY   = 3'd2;
    localparam logic [TF_ADDR_W-1:0] OFS_CTL   = 3'd3;
    localparam logic [TF_ADDR_W-1:0] OFS_STRAP = 3'd5;
    localparam logic [TF_ADDR_W-1:0] OFS_MISC  = 3'd6;

    localparam logic [CFG_W-1:0] KEY_OPEN     = 8'h03;
    localparam logic [CFG_W-1:0] KEY_CLOSE    = 8'h83;
    localparam logic [CFG_W-1:0] CTL_OVERRIDE = 8'h85;
    localparam logic [CFG_W-1:0] PROBE_ARM    = 8'hFF;

    typedef enum logic [1:0] {
        GATE_IDLE,
        GATE_ONE,
        GATE_TWO,
        GATE_OPEN
    } gate_state_e;

    typedef struct packed {
        logic                 valid;
        logic                 write;
        logic                 wide;
        logic [TF_ADDR_W-1:0] addr;
        logic [CFG_W-1:0]     lo;
    } bus_cyc_t;
endpackage

// File: rtl/trapdoor_seq_fsm.sv
// Unlock pattern detector and lock state.
// Walks through two 16-bit error-offset reads and an opening key write.
// Closes again on the closing key. Idle clocks (valid low) leave it unchanged.
module trapdoor_seq_fsm
    import trapdoor_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  bus_cyc_t cyc,
    output logic     open_o
);
    gate_state_e st_q, st_nx;
    logic key_rd, key_wr, close_wr, byte_wr;

    // Decode the cycles that take part in the pattern.
    always_comb begin
        byte_wr  = cyc.write && !cyc.wide;
        key_rd   = !cyc.write && cyc.wide && (cyc.addr == OFS_ERR);
        key_wr   = byte_wr && (cyc.addr == OFS_KEY) && (cyc.lo == KEY_OPEN);
        close_wr = byte_wr && (cyc.addr == OFS_KEY) && (cyc.lo == KEY_CLOSE);
    end

    // Next state: advance on a match, fall back to idle on any other cycle.
    always_comb begin
        st_nx = st_q;
        if (cyc.valid) begin
            unique case (st_q)
                GATE_IDLE: st_nx = key_rd ? GATE_ONE : GATE_IDLE;
                GATE_ONE:  st_nx = key_rd ? GATE_TWO : GATE_IDLE;
                GATE_TWO:  st_nx = key_rd ? GATE_TWO : (key_wr ? GATE_OPEN : GATE_IDLE);
                GATE_OPEN: st_nx = close_wr ? GATE_IDLE : GATE_OPEN;
                default:   st_nx = GATE_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= GATE_IDLE;
        else        st_q <= st_nx;
    end

    assign open_o = (st_q == GATE_OPEN);
endmodule

// File: rtl/trapdoor_cfg_bank.sv
// Configuration register bank: per-drive read and write timing bytes,
// a shared address-setup byte, a drive selector and the override flag.
// Assumes wr_en is asserted only for byte writes taken while the gate is open.
module trapdoor_cfg_bank
    import trapdoor_pkg::*;
#(
    parameter int               NUM_DRIVES = 2,
    parameter logic [CFG_W-1:0] DEF_DATA   = 8'h6B,
    parameter logic [CFG_W-1:0] DEF_ADDR   = 8'h30
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [TF_ADDR_W-1:0]        wr_idx,
    input  logic [CFG_W-1:0]            wr_val,
    output logic [NUM_DRIVES*CFG_W-1:0] prog_rd_o,
    output logic [NUM_DRIVES*CFG_W-1:0] prog_wr_o,
    output logic [CFG_W-1:0]            addr_setup_o,
    output logic                        override_o
);
    localparam int               SEL_W  = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1;
    localparam logic [CFG_W-1:0] NDRV_C = CFG_W'(NUM_DRIVES);

    logic [SEL_W-1:0] sel_q;
    logic [CFG_W-1:0] addr_q;
    logic             ovr_q;
    logic             misc_wr, misc_is_sel;

    // Offset 6 carries either a drive number or the address-setup byte.
    always_comb begin
        misc_wr     = wr_en && (wr_idx == OFS_MISC);
        misc_is_sel = (wr_val < NDRV_C);
    end

    // Drive selector.
    always_ff @(posedge clk) begin
        if (!rst_n)                     sel_q <= '0;
        else if (misc_wr && misc_is_sel) sel_q <= wr_val[SEL_W-1:0];
    end

    // Shared address-setup byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                      addr_q <= DEF_ADDR;
        else if (misc_wr && !misc_is_sel) addr_q <= wr_val;
    end

    // Override flag: set only by the override code in the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)                               ovr_q <= 1'b0;
        else if (wr_en && (wr_idx == OFS_CTL))    ovr_q <= (wr_val == CTL_OVERRIDE);
    end

    for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drv
        logic [CFG_W-1:0] rd_q, wr_q;
        logic             mine;
        assign mine = (sel_q == SEL_W'(d));

        // Read-cycle timing byte of this drive.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   rd_q <= DEF_DATA;
            else if (wr_en && mine && (wr_idx == OFS_RDT)) rd_q <= wr_val;
        end

        // Write-cycle timing byte of this drive.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   wr_q <= DEF_DATA;
            else if (wr_en && mine && (wr_idx == OFS_WRT)) wr_q <= wr_val;
        end

        assign prog_rd_o[d*CFG_W +: CFG_W] = rd_q;
        assign prog_wr_o[d*CFG_W +: CFG_W] = wr_q;
    end

    assign addr_setup_o = addr_q;
    assign override_o   = ovr_q;
endmodule

// File: rtl/trapdoor_clk_probe.sv
// Clock-strap probe: a byte write of the arm code to the strap offset makes
// the next bus cycle, if it is a 16-bit read there, return the strap bit.
// Assumes the top module stops forwarding the read when hit_o is high.
module trapdoor_clk_probe
    import trapdoor_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  bus_cyc_t             cyc,
    input  logic                 strap_clk,
    output logic                 hit_o,
    output logic [TF_DATA_W-1:0] rdata_o
);
    logic armed_q, arm;

    // Arm on the probe write; any other bus cycle disarms.
    always_comb arm = cyc.write && !cyc.wide && (cyc.addr == OFS_STRAP) && (cyc.lo == PROBE_ARM);

    // Arm flag register, updated only on bus cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)         armed_q <= 1'b0;
        else if (cyc.valid) armed_q <= arm;
    end

    assign hit_o   = armed_q && cyc.valid && !cyc.write && cyc.wide && (cyc.addr == OFS_STRAP);
    assign rdata_o = {{(TF_DATA_W-1){1'b0}}, strap_clk};
endmodule

// File: rtl/trapdoor_gate.sv
// Top of the trapdoor configuration gate. Steers host cycles either to the
// task file or to the hidden register bank, and selects the effective timing.
// Assumes at most one host cycle per clock and host timing met by the caller.
module trapdoor_gate
    import trapdoor_pkg::*;
#(
    parameter int               NUM_DRIVES = 2,
    parameter logic [CFG_W-1:0] DEF_DATA   = 8'h6B,
    parameter logic [CFG_W-1:0] DEF_ADDR   = 8'h30
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_valid,
    input  logic                        bus_write,
    input  logic                        bus_wide,
    input  logic [TF_ADDR_W-1:0]        bus_addr,
    input  logic [TF_DATA_W-1:0]        bus_wdata,
    output logic [TF_DATA_W-1:0]        bus_rdata,
    output logic                        tf_valid,
    output logic                        tf_write,
    output logic                        tf_wide,
    output logic [TF_ADDR_W-1:0]        tf_addr,
    output logic [TF_DATA_W-1:0]        tf_wdata,
    input  logic [TF_DATA_W-1:0]        tf_rdata,
    input  logic                        strap_clk,
    output logic [NUM_DRIVES*CFG_W-1:0] rd_time_o,
    output logic [NUM_DRIVES*CFG_W-1:0] wr_time_o,
    output logic [CFG_W-1:0]            addr_setup_o,
    output logic                        timing_override_o,
    output logic                        cfg_unlocked_o
);
    bus_cyc_t                    cyc;
    logic                        gate_open, steer, probe_hit, ovr;
    logic [TF_DATA_W-1:0]        probe_data;
    logic [NUM_DRIVES*CFG_W-1:0] prog_rd, prog_wr;
    logic [CFG_W-1:0]            prog_addr;

    // Bundle the host cycle for the sub-blocks.
    always_comb begin
        cyc.valid = bus_valid;
        cyc.write = bus_write;
        cyc.wide  = bus_wide;
        cyc.addr  = bus_addr;
        cyc.lo    = bus_wdata[CFG_W-1:0];
    end

    trapdoor_seq_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .cyc    (cyc),
        .open_o (gate_open)
    );

    trapdoor_clk_probe u_probe (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc       (cyc),
        .strap_clk (strap_clk),
        .hit_o     (probe_hit),
        .rdata_o   (probe_data)
    );

    // Byte writes are taken by the bank while the gate is open.
    assign steer = gate_open && bus_valid && bus_write && !bus_wide;

    trapdoor_cfg_bank #(
        .NUM_DRIVES (NUM_DRIVES),
        .DEF_DATA   (DEF_DATA),
        .DEF_ADDR   (DEF_ADDR)
    ) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (steer),
        .wr_idx       (bus_addr),
        .wr_val       (bus_wdata[CFG_W-1:0]),
        .prog_rd_o    (prog_rd),
        .prog_wr_o    (prog_wr),
        .addr_setup_o (prog_addr),
        .override_o   (ovr)
    );

    // Forward everything the bank and the probe do not take.
    always_comb begin
        tf_valid  = bus_valid && !steer && !probe_hit;
        tf_write  = bus_write;
        tf_wide   = bus_wide;
        tf_addr   = bus_addr;
        tf_wdata  = bus_wdata;
        bus_rdata = probe_hit ? probe_data : tf_rdata;
    end

    for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_eff
        // Per-drive effective timing: programmed under override, else default.
        assign rd_time_o[d*CFG_W +: CFG_W] = ovr ? prog_rd[d*CFG_W +: CFG_W] : DEF_DATA;
        assign wr_time_o[d*CFG_W +: CFG_W] = ovr ? prog_wr[d*CFG_W +: CFG_W] : DEF_DATA;
    end

    assign addr_setup_o      = ovr ? prog_addr : DEF_ADDR;
    assign timing_override_o = ovr;
    assign cfg_unlocked_o    = gate_open;
endmodule

// File: rtl/trapdoor_gate_chk.sv
// Property checker for trapdoor_gate, attached by bind below.
// Assumes the port names of the top module.
module trapdoor_gate_chk
    import trapdoor_pkg::*;
#(
    parameter int NUM_DRIVES = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_valid,
    input logic                        bus_write,
    input logic                        bus_wide,
    input logic [TF_ADDR_W-1:0]        bus_addr,
    input logic [TF_DATA_W-1:0]        bus_wdata,
    input logic [TF_DATA_W-1:0]        bus_rdata,
    input logic                        tf_valid,
    input logic                        tf_write,
    input logic                        tf_wide,
    input logic [TF_ADDR_W-1:0]        tf_addr,
    input logic [TF_DATA_W-1:0]        tf_wdata,
    input logic [NUM_DRIVES*CFG_W-1:0] rd_time_o,
    input logic [NUM_DRIVES*CFG_W-1:0] wr_time_o,
    input logic [CFG_W-1:0]            addr_setup_o,
    input logic                        timing_override_o,
    input logic                        cfg_unlocked_o
);
    a_r1_reset_closed: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!cfg_unlocked_o && !timing_override_o));

    a_r2_locked_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_unlocked_o && bus_valid && !(!bus_write && bus_wide && bus_addr == OFS_STRAP))
        |-> (tf_valid && tf_write == bus_write && tf_wide == bus_wide
             && tf_addr == bus_addr && tf_wdata == bus_wdata));

    a_r3_open_by_key: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(cfg_unlocked_o))
        |-> $past(bus_valid && bus_write && !bus_wide && bus_addr == OFS_KEY
                  && bus_wdata[CFG_W-1:0] == KEY_OPEN));

    a_r5_open_byte_write_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_unlocked_o && bus_valid && bus_write && !bus_wide) |-> !tf_valid);

    a_r10_close_by_key: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(cfg_unlocked_o))
        |-> $past(bus_valid && bus_write && !bus_wide && bus_addr == OFS_KEY
                  && bus_wdata[CFG_W-1:0] == KEY_CLOSE));

    a_r11_probe_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_wide && bus_addr == OFS_STRAP && !tf_valid)
        |-> (bus_rdata[TF_DATA_W-1:1] == '0));

    a_r12_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_unlocked_o |=> ($stable(rd_time_o) && $stable(wr_time_o)
                             && $stable(addr_setup_o) && $stable(timing_override_o)));
endmodule

bind trapdoor_gate trapdoor_gate_chk #(.NUM_DRIVES(NUM_DRIVES)) u_chk (.*);

// File: tb/tb_trapdoor_gate.sv
// Self-checking bench for trapdoor_gate: directed corner cases plus
// seeded random cycles, compared with a bench-side model of the requirements.
module tb_trapdoor_gate;
    import trapdoor_pkg::*;

    localparam logic [7:0] DEF_D = 8'h6B;
    localparam logic [7:0] DEF_A = 8'h30;

    logic        clk, rst_n;
    logic        bus_valid, bus_write, bus_wide;
    logic [2:0]  bus_addr;
    logic [15:0] bus_wdata, bus_rdata, tf_wdata, tf_rdata;
    logic        tf_valid, tf_write, tf_wide;
    logic [2:0]  tf_addr;
    logic        strap_clk;
    logic [15:0] rd_time_o, wr_time_o;
    logic [7:0]  addr_setup_o;
    logic        timing_override_o, cfg_unlocked_o;

    trapdoor_gate dut (.*);

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int nchk = 0, nerr = 0;
    bit done = 0;

    // Bench model of the requirements.
    int         m_st;
    int         m_sel;
    logic [7:0] m_rd [2];
    logic [7:0] m_wr [2];
    logic [7:0] m_addr;
    bit         m_ovr, m_armed;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_rd();
        return {m_ovr ? m_rd[1] : DEF_D, m_ovr ? m_rd[0] : DEF_D};
    endfunction

    function automatic logic [15:0] exp_wr();
        return {m_ovr ? m_wr[1] : DEF_D, m_ovr ? m_wr[0] : DEF_D};
    endfunction

    function automatic logic [7:0] exp_addr();
        return m_ovr ? m_addr : DEF_A;
    endfunction

    task automatic model_reset();
        m_st = 0; m_sel = 0; m_addr = DEF_A; m_ovr = 0; m_armed = 0;
        for (int i = 0; i < 2; i++) begin m_rd[i] = DEF_D; m_wr[i] = DEF_D; end
    endtask

    task automatic check_regs(string tag);
        chk(tag, cfg_unlocked_o, (m_st == 3), "unlocked");
        chk(tag, timing_override_o, m_ovr, "override");
        chk(tag, rd_time_o, exp_rd(), "rd_time");
        chk(tag, wr_time_o, exp_wr(), "wr_time");
        chk(tag, addr_setup_o, exp_addr(), "addr_setup");
    endtask

    // One host clock: drive, check the same-cycle outputs, update the model,
    // then check the registered outputs after the edge.
    task automatic cyc(bit v, bit w, bit wd, logic [2:0] a, logic [15:0] d);
        bit steer, hit, key_rd, key_wr, close;
        int st0;
        @(negedge clk);
        bus_valid = v; bus_write = w; bus_wide = wd; bus_addr = a; bus_wdata = d;
        tf_rdata = 16'($urandom);
        #1;
        steer = (m_st == 3) && v && w && !wd;
        hit   = m_armed && v && !w && wd && (a == 3'd5);
        chk((m_st == 3) ? "R5" : "R2", tf_valid, v && !steer && !hit, "tf_valid");
        if (v && !steer && !hit) begin
            chk("R2", {tf_write, tf_wide, tf_addr}, {w, wd, a}, "tf_ctrl");
            chk("R2", tf_wdata, d, "tf_wdata");
        end
        if (v && !w)
            chk(hit ? "R11" : "R2", bus_rdata, hit ? {15'd0, strap_clk} : tf_rdata, "bus_rdata");
        @(posedge clk);
        if (v) begin
            st0    = m_st;
            key_rd = !w && wd && (a == 3'd1);
            key_wr = w && !wd && (a == 3'd2) && (d[7:0] == 8'h03);
            close  = w && !wd && (a == 3'd2) && (d[7:0] == 8'h83);
            case (st0)
                0: m_st = key_rd ? 1 : 0;
                1: m_st = key_rd ? 2 : 0;
                2: m_st = key_rd ? 2 : (key_wr ? 3 : 0);
                default: m_st = close ? 0 : 3;
            endcase
            if (st0 == 3 && w && !wd) begin
                case (a)
                    3'd0: m_rd[m_sel] = d[7:0];
                    3'd1: m_wr[m_sel] = d[7:0];
                    3'd3: m_ovr = (d[7:0] == 8'h85);
                    3'd6: if (d[7:0] < 8'd2) m_sel = int'(d[0]); else m_addr = d[7:0];
                    default: ;
                endcase
            end
            m_armed = w && !wd && (a == 3'd5) && (d[7:0] == 8'hFF);
        end
        #1;
        check_regs("R3");
    endtask

    task automatic unlock();
        cyc(1, 0, 1, 3'd1, 16'h0);
        cyc(1, 0, 1, 3'd1, 16'h0);
        cyc(1, 1, 0, 3'd2, 16'h0003);
    endtask

    task automatic relock();
        cyc(1, 1, 0, 3'd2, 16'h0083);
    endtask

    // One configuration write inside its own unlock session.
    task automatic cfg_wr(logic [2:0] a, logic [7:0] val);
        unlock();
        cyc(1, 1, 0, a, {8'h00, val});
        relock();
    endtask

    function automatic logic [15:0] pick_data();
        case ($urandom % 8)
            0: return 16'h0003;
            1: return 16'h0083;
            2: return 16'h0085;
            3: return 16'h00FF;
            4: return 16'($urandom % 2);
            default: return 16'($urandom);
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [15:0] snap_rd;
        void'($urandom(32'd20240611));
        rst_n = 0; bus_valid = 0; bus_write = 0; bus_wide = 0; bus_addr = 0;
        bus_wdata = 0; tf_rdata = 0; strap_clk = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        check_regs("R1");

        // R4: broken patterns leave the gate closed.
        cyc(1, 0, 1, 3'd1, 0); cyc(1, 0, 0, 3'd0, 0); cyc(1, 0, 1, 3'd1, 0);
        cyc(1, 1, 0, 3'd2, 16'h0003);
        chk("R4", cfg_unlocked_o, 0, "one read then key");
        cyc(1, 0, 1, 3'd1, 0); cyc(1, 0, 1, 3'd1, 0); cyc(1, 1, 0, 3'd2, 16'h0005);
        chk("R4", cfg_unlocked_o, 0, "wrong key value");
        cyc(1, 0, 1, 3'd1, 0); cyc(1, 0, 0, 3'd1, 0); cyc(1, 0, 1, 3'd1, 0);
        cyc(1, 1, 0, 3'd2, 16'h0003);
        chk("R4", cfg_unlocked_o, 0, "byte read inside pattern");

        // R3: idle clocks and a third read do not break the pattern.
        cyc(1, 0, 1, 3'd1, 0); cyc(0, 0, 0, 3'd0, 0); cyc(1, 0, 1, 3'd1, 0);
        cyc(1, 0, 1, 3'd1, 0); cyc(1, 1, 0, 3'd2, 16'h0003);
        chk("R3", cfg_unlocked_o, 1, "open after idle and extra read");
        relock();
        chk("R10", cfg_unlocked_o, 0, "closed after close key");

        // R6 R7 R8 R9: programming sequence for both drives.
        cfg_wr(3'd6, 8'h01); cfg_wr(3'd0, 8'h44); cfg_wr(3'd1, 8'h45);
        cfg_wr(3'd6, 8'h00); cfg_wr(3'd0, 8'h58); cfg_wr(3'd1, 8'h59);
        cfg_wr(3'd6, 8'h20);
        chk("R9", rd_time_o, {DEF_D, DEF_D}, "defaults before override");
        cfg_wr(3'd3, 8'h85);
        chk("R7", rd_time_o, 16'h4458, "per-drive read timing");
        chk("R7", wr_time_o, 16'h4559, "per-drive write timing");
        chk("R6", addr_setup_o, 8'h20, "address setup");
        chk("R8", timing_override_o, 1, "override set");

        // R12: closed byte writes to register offsets change nothing.
        snap_rd = rd_time_o;
        cyc(1, 1, 0, 3'd0, 16'h0011); cyc(1, 1, 0, 3'd3, 16'h0000);
        cyc(1, 1, 0, 3'd6, 16'h0001); cyc(1, 1, 0, 3'd1, 16'h0022);
        chk("R12", rd_time_o, snap_rd, "closed writes ignored");
        chk("R12", timing_override_o, 1, "override kept");

        // R5: open wide write and reads still forwarded.
        unlock();
        cyc(1, 1, 1, 3'd0, 16'hBEEF); cyc(1, 0, 0, 3'd7, 0);
        cyc(1, 1, 0, 3'd3, 16'h0000);
        chk("R8", timing_override_o, 0, "override cleared");
        chk("R9", addr_setup_o, DEF_A, "default address setup");
        cyc(1, 1, 0, 3'd3, 16'h0085);
        chk("R9", addr_setup_o, 8'h20, "programmed value kept");
        relock();

        // R11: clock probe with both strap values, and a broken probe.
        strap_clk = 1;
        cyc(1, 1, 0, 3'd5, 16'h00FF); cyc(1, 0, 1, 3'd5, 0);
        strap_clk = 0;
        cyc(1, 1, 0, 3'd5, 16'h00FF); cyc(0, 0, 0, 3'd0, 0); cyc(1, 0, 1, 3'd5, 0);
        cyc(1, 1, 0, 3'd5, 16'h00FF); cyc(1, 0, 0, 3'd0, 0); cyc(1, 0, 1, 3'd5, 0);

        // Random mix.
        for (int it = 0; it < 3000; it++) begin
            strap_clk = 1'($urandom);
            case ($urandom % 10)
                0: unlock();
                1: relock();
                2: begin cyc(1, 1, 0, 3'd5, 16'h00FF); cyc(1, 0, 1, 3'd5, 0); end
                3: cyc(1, 0, 1, 3'd1, 0);
                default: cyc(1'($urandom % 8 != 0), 1'($urandom), 1'($urandom % 4 == 0),
                             3'($urandom), pick_data());
            endcase
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule